// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor port and a main-memory port. It holds recently used 4-byte lines in two ways per set and serves byte reads and byte writes from them. A request whose line is resident finishes in the same cycle it is presented. A request whose line is absent stalls the processor while the block fetches the line from memory. If the line chosen for eviction holds modified data, the block first writes that line back to memory.

Writes go only into the cache and mark the line as modified. Memory sees that data only when the line is evicted or when a flush request walks the whole cache. The flush writes back every modified line and then invalidates every line. The processor holds a request stable until the block raises `cpu_ready`. The memory side uses a valid/ready handshake that moves one whole 32-bit line per transfer.

Top module: `sa2_wb_cache`

## Requirements
- R1: A byte address is split into three fields. Bits [1:0] are the byte offset within the line, the next SET_W bits are the set index, and the remaining upper bits are the tag. Every memory transfer carries the line-aligned address {tag, set, 2'b00}.
- R2: A read whose tag matches a valid line in either way of its set raises `cpu_ready` in the same cycle the request is presented. `cpu_rdata` then shows byte `offset` of that line, where byte k is line bits [8k+7:8k].
- R3: A line can be resident in either way of its set. Two tags that map to the same set can be resident at once, and both then hit. No address ever matches both ways.
- R4: A write that hits replaces only the addressed byte in the cache, marks the line modified and causes no memory transfer. The other three bytes of the line keep their values.
- R5: On a miss the block picks a victim in this order: invalid way 0, then invalid way 1, then the least recently used way. The per-set recency bit is updated on every hit and on every fill.
- R6: A victim is written back, with its old tag's address and all 32 bits, only when it is valid and modified. The write-back completes before the fill read is issued. A clean victim produces no write.
- R7: A miss issues exactly one memory read and installs the line clean. In the cycle after the read completes, the held request finishes as a hit on the filled line.
- R8: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay stable.
- R9: Reset clears every valid bit, modified bit and recency bit. After reset the first access to any address misses and causes no write-back.
- R10: A request with `cpu_flush` set walks every line in ascending order (set first, then way 0 before way 1). It writes back each valid modified line, invalidates all lines and then raises `cpu_ready` for one cycle. Afterwards every access misses and returns the data that was written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_flush | input | 1 | Request is a flush; `cpu_we` and address are ignored |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid while `cpu_ready` |
| cpu_ready | output | 1 | Request completes at this clock edge |
| mem_req | output | 1 | Memory transfer valid |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | 32 | Line being written back |
| mem_rdata | input | 32 | Line returned by memory |
| mem_ready | input | 1 | Memory accepts or returns the line at this edge |

## Verification
The hardest case to reach from the ports is evicting a modified line whose recency bit had been flipped by an earlier hit. Reaching it takes two tags in one set, a touch of one of them, a write to the other and then a third tag. The stimulus builds this sequence explicitly. It then continues with a long run of random accesses over four tags and three sets, so that these collisions recur at varied memory latencies. Flushes are interleaved into that run so that write-back order and post-flush misses are exercised against many different dirty patterns.

// File: rtl/sa2_wb_cache.sv
`timescale 1ns/1ps
module sa2_wb_cache #(
  parameter int ADDR_W = 24,
  parameter int SET_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_flush,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready
);
  localparam int OFF_W = 2;
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam int SETS  = 1 << SET_W;

  typedef enum logic [2:0] {IDLE, WB, FILL, FL_SCAN, FL_WB, FL_DONE} st_t;
  st_t st;

  logic [TAG_W-1:0] tag_q [2][SETS];
  logic [31:0]      dat_q [2][SETS];
  logic [SETS-1:0]  vld_q [2];
  logic [SETS-1:0]  dty_q [2];
  logic [SETS-1:0]  lru_q;
  logic             way_q;
  logic [SET_W:0]   fl_q;

  wire [TAG_W-1:0] a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [SET_W-1:0] a_set = cpu_addr[OFF_W +: SET_W];
  wire [1:0]       a_off = cpu_addr[1:0];
  wire             fl_way = fl_q[0];
  wire [SET_W-1:0] fl_set = fl_q[SET_W:1];

  wire hit0 = vld_q[0][a_set] && (tag_q[0][a_set] == a_tag);
  wire hit1 = vld_q[1][a_set] && (tag_q[1][a_set] == a_tag);
  wire hit  = hit0 | hit1;
  wire hway = hit1;

  wire idle_acc = (st == IDLE) && cpu_req && !cpu_flush;
  wire hit_acc  = idle_acc && hit;
  wire miss     = idle_acc && !hit;
  wire wr_hit   = hit_acc && cpu_we;

  wire vsel    = !vld_q[0][a_set] ? 1'b0 : (!vld_q[1][a_set] ? 1'b1 : lru_q[a_set]);
  wire v_dirty = vld_q[vsel][a_set] && dty_q[vsel][a_set];

  wire fl_dirty   = vld_q[fl_way][fl_set] && dty_q[fl_way][fl_set];
  wire fl_clr     = (st == FL_SCAN) && !fl_dirty;
  wire xfer       = mem_req && mem_ready;
  wire fill_done  = (st == FILL) && mem_ready;
  wire fl_wb_done = (st == FL_WB) && mem_ready;

  wire [31:0] hline = hway ? dat_q[1][a_set] : dat_q[0][a_set];
  assign cpu_rdata = hline[{a_off, 3'b000} +: 8];
  assign cpu_ready = hit_acc || (st == FL_DONE);

  assign mem_req = (st == WB) || (st == FILL) || (st == FL_WB);
  assign mem_we  = (st == WB) || (st == FL_WB);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      WB: begin
        mem_addr  = {tag_q[way_q][a_set], a_set, 2'b00};
        mem_wdata = dat_q[way_q][a_set];
      end
      FILL: mem_addr = {a_tag, a_set, 2'b00};
      FL_WB: begin
        mem_addr  = {tag_q[fl_way][fl_set], fl_set, 2'b00};
        mem_wdata = dat_q[fl_way][fl_set];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      way_q <= 1'b0;
      fl_q  <= '0;
    end else begin
      case (st)
        IDLE: begin
          if (cpu_req && cpu_flush) begin
            st   <= FL_SCAN;
            fl_q <= '0;
          end else if (miss) begin
            way_q <= vsel;
            st    <= v_dirty ? WB : FILL;
          end
        end
        WB:   if (xfer) st <= FILL;
        FILL: if (xfer) st <= IDLE;
        FL_SCAN: begin
          if (fl_dirty)   st <= FL_WB;
          else if (&fl_q) st <= FL_DONE;
          else            fl_q <= fl_q + 1'b1;
        end
        FL_WB:   if (xfer) st <= FL_SCAN;
        FL_DONE: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q[0] <= '0;
      vld_q[1] <= '0;
      dty_q[0] <= '0;
      dty_q[1] <= '0;
      lru_q    <= '0;
    end else begin
      if (hit_acc) lru_q[a_set] <= ~hway;
      if (wr_hit)  dty_q[hway][a_set] <= 1'b1;
      if (fill_done) begin
        vld_q[way_q][a_set] <= 1'b1;
        dty_q[way_q][a_set] <= 1'b0;
        lru_q[a_set]        <= ~way_q;
      end
      if (fl_clr) begin
        vld_q[fl_way][fl_set] <= 1'b0;
        dty_q[fl_way][fl_set] <= 1'b0;
      end
      if (fl_wb_done) dty_q[fl_way][fl_set] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) begin
      dat_q[way_q][a_set] <= mem_rdata;
      tag_q[way_q][a_set] <= a_tag;
    end else if (wr_hit) begin
      dat_q[hway][a_set][{a_off, 3'b000} +: 8] <= cpu_wdata;
    end
  end
endmodule

// File: rtl/sa2_wb_cache_chk.sv
`timescale 1ns/1ps
module sa2_wb_cache_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              hit0,
  input logic              hit1
);
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R1

  AST_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> !(hit0 && hit1)); // R3

  AST_FILL_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready && cpu_req) |=> cpu_ready); // R7

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R8

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!mem_req && !cpu_ready)); // R9
endmodule

bind sa2_wb_cache sa2_wb_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .hit0(hit0), .hit1(hit1)
);

// File: tb/sa2_wb_cache_bench.sv
`timescale 1ns/1ps
module sa2_wb_cache_bench;
  localparam int CLK_P = 10;
  localparam int AW    = 24;
  localparam int SW    = 6;
  localparam int SETS  = 1 << SW;
  localparam int TW    = AW - SW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0, cpu_flush = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0]    cpu_wdata = '0;
  logic [7:0]    cpu_rdata;
  logic          cpu_ready;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          mem_ready = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sa2_wb_cache #(.ADDR_W(AW), .SET_W(SW)) u_sa2_wb_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_flush(cpu_flush), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int n_cmp = 0, n_mis = 0, lat = 0;
  logic [AW-1:0] last_rd = '0;

  logic [TW-1:0] m_tag [2][SETS];
  logic [31:0]   m_dat [2][SETS];
  bit            m_vld [2][SETS];
  bit            m_dty [2][SETS];
  bit            m_lru [SETS];
  logic [31:0]   gmem [int];

  bit            q_we [$];
  logic [AW-1:0] q_a  [$];
  logic [31:0]   q_d  [$];
  string         q_r  [$];

  function automatic logic [31:0] mem_rd(logic [AW-1:0] a);
    if (gmem.exists(int'(a))) return gmem[int'(a)];
    return ({8'h00, a} * 32'h9E3779B1) ^ 32'h5A5AA5A5;
  endfunction

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic push(bit we, logic [AW-1:0] a, logic [31:0] d, string r);
    q_we.push_back(we); q_a.push_back(a); q_d.push_back(d); q_r.push_back(r);
  endtask

  task automatic model_acc(logic [AW-1:0] a, bit we, logic [7:0] wd,
                           output bit h, output logic [7:0] rb);
    logic [SW-1:0] s;
    logic [TW-1:0] t;
    logic [1:0]    o;
    logic [AW-1:0] la;
    bit w, v;
    s = a[2 +: SW]; t = a[AW-1 -: TW]; o = a[1:0];
    h = 1'b0; w = 1'b0;
    if (m_vld[0][s] && m_tag[0][s] == t) begin h = 1'b1; w = 1'b0; end
    else if (m_vld[1][s] && m_tag[1][s] == t) begin h = 1'b1; w = 1'b1; end
    if (!h) begin
      v = !m_vld[0][s] ? 1'b0 : (!m_vld[1][s] ? 1'b1 : m_lru[s]);
      if (m_vld[v][s] && m_dty[v][s]) begin
        la = {m_tag[v][s], s, 2'b00};
        gmem[int'(la)] = m_dat[v][s];
        push(1'b1, la, m_dat[v][s], "R6");
      end
      la = {t, s, 2'b00};
      push(1'b0, la, 32'h0, "R7");
      m_dat[v][s] = mem_rd(la);
      m_tag[v][s] = t; m_vld[v][s] = 1'b1; m_dty[v][s] = 1'b0;
      w = v;
    end
    rb = m_dat[w][s][{o, 3'b000} +: 8];
    if (we) begin
      m_dat[w][s][{o, 3'b000} +: 8] = wd;
      m_dty[w][s] = 1'b1;
    end
    m_lru[s] = ~w;
  endtask

  task automatic model_flush();
    logic [AW-1:0] la;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 2; w++) begin
        if (m_vld[w][s] && m_dty[w][s]) begin
          la = {m_tag[w][s], s[SW-1:0], 2'b00};
          gmem[int'(la)] = m_dat[w][s];
          push(1'b1, la, m_dat[w][s], "R10");
        end
        m_vld[w][s] = 1'b0; m_dty[w][s] = 1'b0;
      end
  endtask

  // memory responder, compared against the model's expected transfers
  initial begin
    int wcnt;
    logic [AW-1:0] seen;
    wcnt = -1; seen = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ready = 1'b0; wcnt = -1;
      end else if (mem_ready) begin
        mem_ready = 1'b0;
      end else if (mem_req) begin
        if (wcnt < 0) begin wcnt = lat; seen = mem_addr; end
        if (wcnt > 0) wcnt--;
        else begin
          chk(mem_addr == seen, "R8", {8'h0, mem_addr}, {8'h0, seen});
          if (q_we.size() == 0) begin
            chk(1'b0, "R6 unexpected transfer", {8'h0, mem_addr}, 32'h0);
          end else begin
            chk(mem_we == q_we[0] && mem_addr == q_a[0], q_r[0],
                {7'h0, mem_we, mem_addr}, {7'h0, q_we[0], q_a[0]});
            if (q_we[0]) chk(mem_wdata == q_d[0], q_r[0], mem_wdata, q_d[0]);
            void'(q_we.pop_front()); void'(q_a.pop_front());
            void'(q_d.pop_front());  void'(q_r.pop_front());
          end
          if (!mem_we) begin
            mem_rdata = mem_rd(mem_addr);
            last_rd = mem_addr;
          end
          mem_ready = 1'b1;
          wcnt = -1;
        end
      end
    end
  end

  task automatic access(logic [AW-1:0] a, bit we, logic [7:0] wd, bit fl,
                        string r, output bit was_hit);
    bit eh, done;
    logic [7:0] eb, got;
    int cyc;
    eh = 1'b0; eb = '0;
    if (fl) model_flush();
    else model_acc(a, we, wd, eh, eb);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_flush = fl; cpu_addr = a; cpu_wdata = wd;
    cyc = 0; done = 1'b0;
    while (!done) begin
      #(CLK_P/4);
      if (cpu_ready) done = 1'b1;
      else begin
        cyc++;
        if (cyc > 4000) begin
          chk(1'b0, {r, " watchdog"}, cyc, 0);
          done = 1'b1;
        end else @(negedge clk);
      end
    end
    got = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_flush = 1'b0;
    was_hit = (cyc == 0);
    if (!fl) chk(was_hit == eh, {r, " hit timing"}, {31'h0, was_hit}, {31'h0, eh});
    if (!fl && !we) chk(got == eb, {r, " read byte"}, {24'h0, got}, {24'h0, eb});
    chk(q_we.size() == 0, fl ? "R10 pending" : "R6 pending", q_we.size(), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    chk(1'b0, "global watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    bit h;
    logic [AW-1:0] A, B, C, ra;
    for (int s = 0; s < SETS; s++) begin
      m_lru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin m_vld[w][s] = 1'b0; m_dty[w][s] = 1'b0; end
    end
    A = 24'hABCDE7; B = A ^ 24'h100000; C = A ^ 24'h200000;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!cpu_ready && !mem_req, "R9 reset outputs", {cpu_ready, mem_req}, 0);
    rst_n = 1'b1;

    access(A, 1'b0, 8'h0, 1'b0, "R9", h);
    chk(!h, "R9 first access misses", h, 0);
    chk(last_rd == 24'hABCDE4, "R1 line address", {8'h0, last_rd}, 32'h00ABCDE4);
    lat = 2;
    access(A, 1'b0, 8'h0, 1'b0, "R2", h);
    chk(h, "R2 same-cycle hit", h, 1);

    access(24'hABCDE5, 1'b1, 8'h3C, 1'b0, "R4", h);
    chk(h, "R4 write hit", h, 1);
    for (int i = 0; i < 4; i++) access(24'hABCDE4 + i, 1'b0, 8'h0, 1'b0, "R4", h);

    access(B, 1'b0, 8'h0, 1'b0, "R3", h);
    access(A, 1'b0, 8'h0, 1'b0, "R3", h);
    chk(h, "R3 tag A resident", h, 1);
    access(B, 1'b0, 8'h0, 1'b0, "R3", h);
    chk(h, "R3 tag B resident", h, 1);

    lat = 1;
    access(A, 1'b0, 8'h0, 1'b0, "R5", h);
    access(C, 1'b0, 8'h0, 1'b0, "R5", h);
    access(A, 1'b0, 8'h0, 1'b0, "R5", h);
    chk(h, "R5 recent line kept", h, 1);
    access(B, 1'b0, 8'h0, 1'b0, "R5", h);
    chk(!h, "R5 old line evicted", h, 0);

    access(B ^ 24'h000002, 1'b1, 8'hA5, 1'b0, "R6", h);
    access(A, 1'b0, 8'h0, 1'b0, "R6", h);
    access(C, 1'b0, 8'h0, 1'b0, "R6", h);
    access(B ^ 24'h000002, 1'b0, 8'h0, 1'b0, "R6", h);
    chk(!h, "R6 evicted dirty line refetched", h, 0);

    lat = 0;
    access(24'h0, 1'b0, 8'h0, 1'b1, "R10", h);
    access(24'hABCDE5, 1'b0, 8'h0, 1'b0, "R10", h);
    chk(!h, "R10 miss after flush", h, 0);

    for (int i = 0; i < 1500; i++) begin
      lat = i % 3;
      ra = {16'hA000 + 16'($urandom % 4), 6'($urandom % 3), 2'($urandom)};
      if (i % 300 == 299) access(24'h0, 1'b0, 8'h0, 1'b1, "R10", h);
      else access(ra, 1'($urandom), 8'($urandom), 1'b0, "R7", h);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule